// File: doc/BRIEF.md
# Masked Compare Periodic Interrupt Timer

This block is a 32-bit up-counter on the peripheral clock. It raises an interrupt when the count agrees with a programmed compare value on every bit that a mask selects. Bits outside the mask are don't-care. One compare/mask pair can therefore fire at several counts within a single wrap of the counter. For example, it can hit twice every sixteen counts, or once every 2^k counts when only the low bits are masked in.

Software uses a small word-addressed register port. It sets the compare value and the mask, and it can read or overwrite the live count. A control word holds three bits: a run enable, an option that reloads the counter to zero after a hit, and a sticky hit flag. The flag is cleared by writing 1 to it. The flag drives the interrupt line directly. Reading the counter after an interrupt shows which matching count caused it.

Top module: `masked_match_timer`

## Requirements
- R1: After reset, compare, mask, control and counter all read 0 and `irq_o` is 0.
- R2: While enable (control bit 0) is 1 and no counter write occurs, the counter increases by one on every clock edge.
- R3: While enable is 0, the counter keeps its value and no hit is detected, even with a mask that would match any count.
- R4: A hit occurs when `(count ^ compare) & mask` is zero. With mask 0xD and compare 0x9, the first hits after a count of 0 are at counts 9 and 11, and not at 10, 12 or 13.
- R5: Without clear-on-hit, the counter keeps counting through a hit, and bits outside the mask are ignored. With the R4 setting the next hit after 11 is at 25 (0x19).
- R6: The flag is set on the edge at which a hit is detected. At that edge the counter has already moved on, so reading it then gives the hit count plus one.
- R7: The flag (control bit 2) stays set until software writes a 1 to bit 2 at address 2. Writing 0 there leaves it set.
- R8: If a hit and a flag-clear write fall on the same edge, the flag stays set.
- R9: With clear-on-hit (control bit 1) set, the counter loads 0 on the edge that detects a hit.
- R10: A counter write (address 3) loads the written value at the next edge. On that edge no hit is detected, even if the old count matched.
- R11: Compare (address 0), mask (address 1) and control (address 2) read back the values last written. The counter wraps from 0xFFFFFFFF to 0.
- R12: `irq_o` equals the flag at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Peripheral clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 1 | Register access strobe |
| wr_i | input | 1 | Write when 1, read when 0 |
| addr_i | input | 2 | Register index: 0 compare, 1 mask, 2 control, 3 counter |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| irq_o | output | 1 | Level interrupt, equal to the sticky flag |

## Verification
The matcher is tested with three kinds of mask:
- A sparse four-bit mask separates a true masked compare from an exact compare: an exact compare would fire only at 9, while a masked one also fires at 11 and at 25.
- An all-ones mask with clear-on-hit shows the counter returning to zero, not the don't-care behaviour.
- An all-zero mask matches every count. It shows that the enable gates detection, and that a hit outranks a flag clear on the same edge.

A counter write onto a matching value exposes any match evaluated on the stale count.

// File: rtl/mmt_pkg.sv
package mmt_pkg;
  localparam int unsigned CTRL_EN   = 0;
  localparam int unsigned CTRL_CLR  = 1;
  localparam int unsigned CTRL_FLAG = 2;

  typedef enum logic [1:0] {
    REG_CMP  = 2'd0,
    REG_MASK = 2'd1,
    REG_CTRL = 2'd2,
    REG_CNT  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/mmt_regfile.sv
module mmt_regfile
  import mmt_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              wr_i,
  input  logic [1:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] cmp_o,
  output logic [DATA_W-1:0] mask_o,
  output logic              en_o,
  output logic              clr_on_hit_o,
  output logic              cnt_wr_o,
  output logic              flag_clr_o
);
  logic wr_en;
  assign wr_en = sel_i & wr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmp_o        <= '0;
      mask_o       <= '0;
      en_o         <= 1'b0;
      clr_on_hit_o <= 1'b0;
    end else if (wr_en) begin
      case (reg_sel_e'(addr_i))
        REG_CMP:  cmp_o  <= wdata_i;
        REG_MASK: mask_o <= wdata_i;
        REG_CTRL: begin
          en_o         <= wdata_i[CTRL_EN];
          clr_on_hit_o <= wdata_i[CTRL_CLR];
        end
        default: ;
      endcase
    end
  end

  assign cnt_wr_o   = wr_en && (reg_sel_e'(addr_i) == REG_CNT);
  assign flag_clr_o = wr_en && (reg_sel_e'(addr_i) == REG_CTRL) && wdata_i[CTRL_FLAG];
endmodule

// File: rtl/mmt_matcher.sv
module mmt_matcher #(
  parameter int unsigned DATA_W = 32
) (
  input  logic [DATA_W-1:0] cnt_i,
  input  logic [DATA_W-1:0] cmp_i,
  input  logic [DATA_W-1:0] mask_i,
  input  logic              en_i,
  input  logic              cnt_wr_i,
  output logic              hit_o
);
  logic [DATA_W-1:0] bit_ok;

  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    // unmasked bits always agree
    assign bit_ok[b] = ~mask_i[b] | ~(cnt_i[b] ^ cmp_i[b]);
  end

  assign hit_o = en_i & ~cnt_wr_i & (&bit_ok);
endmodule

// File: rtl/mmt_counter.sv
module mmt_counter #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              clr_on_hit_i,
  input  logic              hit_i,
  input  logic              cnt_wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] cnt_o
);
  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_o <= '0;
    else if (cnt_wr_i)            cnt_o <= wdata_i;
    else if (en_i) begin
      if (clr_on_hit_i && hit_i)  cnt_o <= '0;
      else                        cnt_o <= cnt_o + ONE;
    end
  end
endmodule

// File: rtl/mmt_flag.sv
module mmt_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hit_i,
  input  logic clr_i,
  output logic flag_o
);
  // hit outranks a same-edge clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_o <= 1'b0;
    else if (hit_i)  flag_o <= 1'b1;
    else if (clr_i)  flag_o <= 1'b0;
  end
endmodule

// File: rtl/masked_match_timer.sv
module masked_match_timer
  import mmt_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              wr_i,
  input  logic [1:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  logic [DATA_W-1:0] cmp, mask, cnt;
  logic en, clr_on_hit, cnt_wr, flag_clr, hit, flag;

  mmt_regfile #(.DATA_W(DATA_W)) u_regs (
    .clk_i, .rst_ni, .sel_i, .wr_i, .addr_i, .wdata_i,
    .cmp_o(cmp), .mask_o(mask), .en_o(en), .clr_on_hit_o(clr_on_hit),
    .cnt_wr_o(cnt_wr), .flag_clr_o(flag_clr)
  );

  mmt_matcher #(.DATA_W(DATA_W)) u_match (
    .cnt_i(cnt), .cmp_i(cmp), .mask_i(mask), .en_i(en),
    .cnt_wr_i(cnt_wr), .hit_o(hit)
  );

  mmt_counter #(.DATA_W(DATA_W)) u_cnt (
    .clk_i, .rst_ni, .en_i(en), .clr_on_hit_i(clr_on_hit), .hit_i(hit),
    .cnt_wr_i(cnt_wr), .wdata_i, .cnt_o(cnt)
  );

  mmt_flag u_flag (
    .clk_i, .rst_ni, .hit_i(hit), .clr_i(flag_clr), .flag_o(flag)
  );

  always_comb begin
    rdata_o = '0;
    case (reg_sel_e'(addr_i))
      REG_CMP:  rdata_o = cmp;
      REG_MASK: rdata_o = mask;
      REG_CTRL: begin
        rdata_o[CTRL_EN]   = en;
        rdata_o[CTRL_CLR]  = clr_on_hit;
        rdata_o[CTRL_FLAG] = flag;
      end
      REG_CNT:  rdata_o = cnt;
      default:  rdata_o = '0;
    endcase
  end

  assign irq_o = flag;
endmodule

// File: rtl/masked_match_timer_sva.sv
module masked_match_timer_sva #(
  parameter int unsigned DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [DATA_W-1:0] wdata_i,
  input logic [DATA_W-1:0] cnt,
  input logic              en,
  input logic              clr_on_hit,
  input logic              cnt_wr,
  input logic              flag_clr,
  input logic              hit,
  input logic              irq_o
);
  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

  assert_advance_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en && !cnt_wr && !(clr_on_hit && hit)) |=> cnt == $past(cnt) + ONE);

  assert_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en && !cnt_wr) |=> $stable(cnt));

  assert_no_hit_off_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en |-> !hit);

  assert_flag_set_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit |=> irq_o);

  assert_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !flag_clr) |=> irq_o);

  assert_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_clr && !hit) |=> !irq_o);

  assert_reload_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en && clr_on_hit && hit) |=> cnt == '0);

  assert_cnt_write_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_wr |=> cnt == $past(wdata_i));

  assert_write_no_hit_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_wr |-> !hit);
endmodule

bind masked_match_timer masked_match_timer_sva #(.DATA_W(DATA_W)) u_sva (
  .clk_i(clk_i), .rst_ni(rst_ni), .wdata_i(wdata_i), .cnt(cnt), .en(en),
  .clr_on_hit(clr_on_hit), .cnt_wr(cnt_wr), .flag_clr(flag_clr),
  .hit(hit), .irq_o(irq_o)
);

// File: tb/masked_match_timer_test.sv
module masked_match_timer_test;
  localparam int CLK_P = 10;
  localparam logic [1:0] A_CMP = 2'd0, A_MASK = 2'd1, A_CTRL = 2'd2, A_CNT = 2'd3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sel = 1'b0, wr = 1'b0;
  logic [1:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic irq;

  int checks = 0, failures = 0;

  typedef struct {
    bit          is_irq;
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t sb[$];
  event smp;

  always #(CLK_P/2) clk = ~clk;

  masked_match_timer uut (
    .clk_i(clk), .rst_ni(rst_n), .sel_i(sel), .wr_i(wr), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  // monitor: pops expectations and compares
  initial begin
    forever begin
      @(smp);
      while (sb.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it = sb.pop_front();
        act = it.is_irq ? {31'd0, irq} : rdata;
        checks++;
        if (act !== it.exp) begin
          failures++;
          $display("FAIL %s actual=0x%08h expected=0x%08h", it.tag, act, it.exp);
        end
      end
    end
  end

  // writes take effect at the next rising edge
  task automatic wr_reg(input logic [1:0] a, input logic [31:0] d);
    sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    sel = 1'b0; wr = 1'b0;
  endtask

  task automatic rd_chk(input logic [1:0] a, input logic [31:0] e, input string tag);
    addr = a;
    sb.push_back('{1'b0, e, tag});
    #(CLK_P/4); ->smp; #1;
  endtask

  task automatic irq_chk(input logic e, input string tag);
    sb.push_back('{1'b1, {31'd0, e}, tag});
    #1; ->smp; #1;
  endtask

  task automatic wait_irq(input int max_cyc, input string tag);
    int n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!irq && n < max_cyc);
    if (!irq) begin
      checks++; failures++;
      $display("FAIL %s irq timeout actual=0 expected=1", tag);
    end
  endtask

  initial begin
    #(CLK_P * 100000);
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_P*2 + 2);
    // R1 reset state
    rd_chk(A_CMP, 0, "R1 cmp");
    rd_chk(A_MASK, 0, "R1 mask");
    rd_chk(A_CTRL, 0, "R1 ctrl");
    rd_chk(A_CNT, 0, "R1 cnt");
    irq_chk(1'b0, "R1 irq");
    rst_n = 1'b1;
    @(posedge clk); #1;

    // R11 readback
    wr_reg(A_MASK, 32'h0000_000D);
    wr_reg(A_CMP, 32'h0000_0009);
    wr_reg(A_CTRL, 32'h2);
    rd_chk(A_CMP, 32'h9, "R11 cmp");
    rd_chk(A_MASK, 32'hD, "R11 mask");
    rd_chk(A_CTRL, 32'h2, "R11 ctrl");

    // R4/R5/R6 masked example, free running
    wr_reg(A_CNT, 0);
    wr_reg(A_CTRL, 32'h5);
    wait_irq(40, "R4 first");
    rd_chk(A_CNT, 10, "R4 R6 first hit at 9");
    wr_reg(A_CTRL, 32'h5);
    irq_chk(1'b0, "R7 clear");
    wait_irq(40, "R4 second");
    rd_chk(A_CNT, 12, "R4 second hit at 11");
    wr_reg(A_CTRL, 32'h5);
    wait_irq(40, "R5 third");
    rd_chk(A_CNT, 26, "R5 next hit at 25");

    // R7 sticky, write 0 does not clear
    wr_reg(A_CTRL, 32'h0);
    repeat (20) @(posedge clk); #1;
    irq_chk(1'b1, "R7 sticky");
    rd_chk(A_CTRL, 32'h4, "R7 R12 flag in ctrl");
    wr_reg(A_CTRL, 32'h4);
    irq_chk(1'b0, "R7 w1c");

    // R8 hit beats clear
    wr_reg(A_MASK, 32'h0);
    wr_reg(A_CTRL, 32'h1);
    repeat (3) @(posedge clk); #1;
    wr_reg(A_CTRL, 32'h5);
    irq_chk(1'b1, "R8 hit over clear");

    // R9 clear on hit
    wr_reg(A_CTRL, 32'h0);
    wr_reg(A_MASK, 32'hFFFF_FFFF);
    wr_reg(A_CMP, 32'd5);
    wr_reg(A_CNT, 0);
    wr_reg(A_CTRL, 32'h7);
    wait_irq(40, "R9 first");
    rd_chk(A_CNT, 0, "R9 reload");
    wr_reg(A_CTRL, 32'h7);
    wait_irq(40, "R9 second");
    rd_chk(A_CNT, 0, "R9 reload again");

    // R3 hold and no hit when disabled
    wr_reg(A_CTRL, 32'h4);
    wr_reg(A_MASK, 32'h0);
    rd_chk(A_CNT, 1, "R3 cnt");
    repeat (10) @(posedge clk); #1;
    rd_chk(A_CNT, 1, "R3 hold");
    irq_chk(1'b0, "R3 no hit");

    // R10 write suppresses hit
    wr_reg(A_MASK, 32'hFFFF_FFFF);
    wr_reg(A_CMP, 32'd49);
    wr_reg(A_CNT, 32'd49);
    wr_reg(A_CTRL, 32'h1);
    wr_reg(A_CNT, 32'd1000);
    wr_reg(A_CTRL, 32'h0);
    irq_chk(1'b0, "R10 no hit on write");
    rd_chk(A_CNT, 32'd1001, "R10 loaded");

    // R2 advance count
    wr_reg(A_CMP, 32'h0);
    wr_reg(A_CNT, 32'd100);
    wr_reg(A_CTRL, 32'h1);
    repeat (7) @(posedge clk); #1;
    wr_reg(A_CTRL, 32'h0);
    rd_chk(A_CNT, 32'd108, "R2 advance");
    irq_chk(1'b0, "R2 no stray hit");

    // R11 wrap
    wr_reg(A_CNT, 32'hFFFF_FFFF);
    wr_reg(A_CTRL, 32'h1);
    wr_reg(A_CTRL, 32'h0);
    rd_chk(A_CNT, 32'h0, "R11 wrap");
    irq_chk(1'b0, "R12 irq follows flag");

    #(CLK_P);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule